// File: doc/BRIEF.md
# Length-Field Message Splitter for Concatenated OUT Transfers

This block sits between the byte stream of a USB OUT endpoint and a descriptor-driven DMA writer. A host may send several variable-length messages back to back. Packetisation ignores message edges, so one packet can close one message and open the next. Each message carries its own 16-bit little-endian length at a programmable byte offset, counted from the message's first byte. The block picks out that field while the bytes stream past, even when its two bytes land in different packets. It then counts payload bytes against the value, including the length bytes themselves. When the count reaches the length, the block retires the active descriptor.

Each accepted byte produces one write, with an address equal to the descriptor base plus the byte's offset in the message. If the retiring descriptor names a valid successor, the successor is loaded on the same edge and the following byte goes to the new base. If it names none, the enable bit drops. The retirement is flagged as an overrun when the packet still had bytes left. Descriptors are supplied as register inputs. The block does not receive packets, fetch descriptors or drive a memory bus.

Top module: `lenfield_dma_splitter`

## Requirements
- R1: After reset the enable, write strobe, retire pulse, both extraction flags, drop-error flag, extracted length (0) and retire code (2'b00) are all low.
- R2: `start_i` while disabled loads the descriptor inputs and sets `dma_en_o`. Each byte accepted while enabled appears one cycle later on `wr_valid_o`/`wr_data_o` with `wr_addr_o` = base + offset of the byte within the current message.
- R3: The byte at offset `pos` is captured as bits 7:0 of the length and sets `lo_seen_o`. The byte at offset `pos+1` is captured as bits 15:8 and sets `hi_seen_o`. `buf_len_o` shows the captured value.
- R4: Extraction holds its state across packet boundaries (`in_last_i`), so a length field split between two packets is captured correctly.
- R5: When the high byte has been captured and the number of bytes taken for the message is at least the length, `retire_o` pulses for one cycle with the write of that byte. `retire_len_o` carries the length, and `retire_code_o` is 2'b01 for a normal finish.
- R6: On a retire whose descriptor has the next-valid bit set, the next-descriptor inputs are loaded on the same edge. The next byte is written at the new base, the offset restarts at 0 and both flags and the length clear.
- R7: On a retire with next-valid 0 on a byte that is not the last of its packet, `retire_code_o` is 2'b10 (overrun) and `dma_en_o` clears.
- R8: On a retire with next-valid 0 on the last byte of a packet, `retire_code_o` is 2'b01 and `dma_en_o` clears.
- R9: A byte arriving while disabled is not written and sets `drop_err_o`, which stays set until reset.
- R10: A length of zero, or any length below `pos+2`, retires the descriptor on the byte that completes the length field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Load first descriptor and enable (ignored while enabled) |
| dsc_addr_i | input | AW | Base address of the first descriptor |
| dsc_pos_i | input | POS_W | Length-field offset of the first descriptor |
| dsc_nv_i | input | 1 | Next-valid bit of the first descriptor |
| nxt_addr_i | input | AW | Base address of the following descriptor |
| nxt_pos_i | input | POS_W | Length-field offset of the following descriptor |
| nxt_nv_i | input | 1 | Next-valid bit of the following descriptor |
| in_valid_i | input | 1 | Payload byte present |
| in_data_i | input | 8 | Payload byte |
| in_last_i | input | 1 | Byte is the last of its packet |
| wr_valid_o | output | 1 | Write strobe |
| wr_addr_o | output | AW | Write address |
| wr_data_o | output | 8 | Write data |
| lo_seen_o | output | 1 | Low length byte captured |
| hi_seen_o | output | 1 | High length byte captured |
| buf_len_o | output | 16 | Captured length of the active descriptor |
| retire_o | output | 1 | One-cycle retire pulse |
| retire_code_o | output | 2 | Last retire code: 01 normal, 10 overrun |
| retire_len_o | output | 16 | Length of the last retired descriptor |
| dma_en_o | output | 1 | DMA enable |
| drop_err_o | output | 1 | Sticky dropped-byte error |

## Verification
Every result is registered, so it is due on the output one clock edge after the input that causes it. This covers the write of a byte, its flag updates, a retire pulse with its code and length, the enable drop, the descriptor switch and the drop-error flag. The bench drives inputs at the falling edge. After each rising edge it advances a behavioural queue-based model by exactly one step, and at the next falling edge it compares every output against that model. This keeps expected and actual results in the same cycle with no slack. Separate checks then inspect the logged write addresses and retire records against hand-computed values for the split length field, the mid-packet chain, the zero length and the overrun.

// File: rtl/lds_pkg.sv
package lds_pkg;
    typedef enum logic [1:0] {
        RC_ACTIVE  = 2'b00,
        RC_DONE    = 2'b01,
        RC_OVERRUN = 2'b10
    } ret_code_e;
endpackage

// File: rtl/lds_len_capture.sv
module lds_len_capture #(
    parameter int POS_W = 8,
    parameter int CW    = 17
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             take_i,
    input  logic [CW-1:0]    off_i,
    input  logic [POS_W-1:0] pos_i,
    input  logic [7:0]       data_i,
    output logic             lo_o,
    output logic             hi_o,
    output logic [15:0]      len_o,
    output logic             hi_next_o,
    output logic [15:0]      len_next_o
);
    typedef struct packed {
        logic        lo;
        logic        hi;
        logic [15:0] len;
    } cap_t;

    cap_t cap_q, cap_d, view;
    logic [CW-1:0] lo_off, hi_off;

    assign lo_off = CW'(pos_i);
    assign hi_off = CW'(pos_i) + CW'(1);

    always_comb begin
        view = cap_q;
        if (take_i) begin
            if (!cap_q.lo && off_i == lo_off) begin
                view.lo       = 1'b1;
                view.len[7:0] = data_i;
            end
            if (!cap_q.hi && off_i == hi_off) begin
                view.hi        = 1'b1;
                view.len[15:8] = data_i;
            end
        end
        cap_d = view;
        if (clr_i) cap_d = '0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cap_q <= '0;
        else         cap_q <= cap_d;
    end

    assign lo_o       = cap_q.lo;
    assign hi_o       = cap_q.hi;
    assign len_o      = cap_q.len;
    assign hi_next_o  = view.hi;
    assign len_next_o = view.len;

    // R3
    hi_after_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cap_q.hi |-> cap_q.lo);

    // R6
    clear_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (!cap_q.lo && !cap_q.hi && cap_q.len == 16'd0));
endmodule

// File: rtl/lds_msg_ctr.sv
module lds_msg_ctr #(
    parameter int AW = 16,
    parameter int CW = 17
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [AW-1:0] base_i,
    input  logic          step_i,
    output logic [CW-1:0] off_o,
    output logic [CW-1:0] off_next_o,
    output logic [AW-1:0] addr_o
);
    typedef struct packed {
        logic [AW-1:0] base;
        logic [CW-1:0] off;
    } ctr_t;

    ctr_t ctr_q, ctr_d;

    always_comb begin
        ctr_d = ctr_q;
        if (load_i) begin
            ctr_d.base = base_i;
            ctr_d.off  = '0;
        end else if (step_i) begin
            ctr_d.off = ctr_q.off + CW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) ctr_q <= '0;
        else         ctr_q <= ctr_d;
    end

    assign off_o      = ctr_q.off;
    assign off_next_o = ctr_q.off + CW'(1);
    assign addr_o     = ctr_q.base + AW'(ctr_q.off);

    // R2
    offset_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !load_i) |=> (ctr_q.off == $past(ctr_q.off) + CW'(1)));

    // R6
    offset_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (ctr_q.off == '0 && ctr_q.base == $past(base_i)));
endmodule

// File: rtl/lenfield_dma_splitter.sv
module lenfield_dma_splitter
    import lds_pkg::*;
#(
    parameter int AW    = 16,
    parameter int POS_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [AW-1:0]    dsc_addr_i,
    input  logic [POS_W-1:0] dsc_pos_i,
    input  logic             dsc_nv_i,
    input  logic [AW-1:0]    nxt_addr_i,
    input  logic [POS_W-1:0] nxt_pos_i,
    input  logic             nxt_nv_i,
    input  logic             in_valid_i,
    input  logic [7:0]       in_data_i,
    input  logic             in_last_i,
    output logic             wr_valid_o,
    output logic [AW-1:0]    wr_addr_o,
    output logic [7:0]       wr_data_o,
    output logic             lo_seen_o,
    output logic             hi_seen_o,
    output logic [15:0]      buf_len_o,
    output logic             retire_o,
    output logic [1:0]       retire_code_o,
    output logic [15:0]      retire_len_o,
    output logic             dma_en_o,
    output logic             drop_err_o
);
    localparam int CW = (((POS_W + 2) > 16) ? (POS_W + 2) : 16) + 1;

    typedef struct packed {
        logic             en;
        logic [POS_W-1:0] pos;
        logic             nv;
        logic             err;
        logic             wv;
        logic [AW-1:0]    wa;
        logic [7:0]       wd;
        logic             ret;
        ret_code_e        rc;
        logic [15:0]      rl;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic          accept, start_ok, chain, reload, done;
    logic [AW-1:0] load_base;
    logic [CW-1:0] off_cur, off_nxt;
    logic [AW-1:0] cur_addr;
    logic          hi_next;
    logic [15:0]   len_next;
    logic          cap_lo, cap_hi;
    logic [15:0]   cap_len;

    assign accept    = in_valid_i && ctl_q.en;
    assign start_ok  = start_i && !ctl_q.en;
    assign done      = accept && hi_next &&
                       (off_nxt >= {{(CW-16){1'b0}}, len_next});
    assign chain     = done && ctl_q.nv;
    assign reload    = start_ok || chain;
    assign load_base = chain ? nxt_addr_i : dsc_addr_i;

    lds_msg_ctr #(.AW(AW), .CW(CW)) u_ctr (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (reload),
        .base_i     (load_base),
        .step_i     (accept),
        .off_o      (off_cur),
        .off_next_o (off_nxt),
        .addr_o     (cur_addr)
    );

    lds_len_capture #(.POS_W(POS_W), .CW(CW)) u_cap (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_i      (reload),
        .take_i     (accept),
        .off_i      (off_cur),
        .pos_i      (ctl_q.pos),
        .data_i     (in_data_i),
        .lo_o       (cap_lo),
        .hi_o       (cap_hi),
        .len_o      (cap_len),
        .hi_next_o  (hi_next),
        .len_next_o (len_next)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.wv  = 1'b0;
        ctl_d.ret = 1'b0;
        if (in_valid_i && !ctl_q.en) ctl_d.err = 1'b1;
        if (start_ok) begin
            ctl_d.en  = 1'b1;
            ctl_d.pos = dsc_pos_i;
            ctl_d.nv  = dsc_nv_i;
        end
        if (accept) begin
            ctl_d.wv = 1'b1;
            ctl_d.wa = cur_addr;
            ctl_d.wd = in_data_i;
            if (done) begin
                ctl_d.ret = 1'b1;
                ctl_d.rl  = len_next;
                if (ctl_q.nv) begin
                    ctl_d.rc  = RC_DONE;
                    ctl_d.pos = nxt_pos_i;
                    ctl_d.nv  = nxt_nv_i;
                end else begin
                    ctl_d.en = 1'b0;
                    ctl_d.rc = in_last_i ? RC_DONE : RC_OVERRUN;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctl_q    <= '0;
            ctl_q.rc <= RC_ACTIVE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign wr_valid_o    = ctl_q.wv;
    assign wr_addr_o     = ctl_q.wa;
    assign wr_data_o     = ctl_q.wd;
    assign lo_seen_o     = cap_lo;
    assign hi_seen_o     = cap_hi;
    assign buf_len_o     = cap_len;
    assign retire_o      = ctl_q.ret;
    assign retire_code_o = ctl_q.rc;
    assign retire_len_o  = ctl_q.rl;
    assign dma_en_o      = ctl_q.en;
    assign drop_err_o    = ctl_q.err;

    // R5
    retire_with_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctl_q.ret |-> ctl_q.wv);

    // R5
    retire_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctl_q.ret |=> !ctl_q.ret);

    // R7
    overrun_disables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.ret && ctl_q.rc == RC_OVERRUN) |-> !ctl_q.en);

    // R9
    no_write_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctl_q.en |=> !ctl_q.wv);

    // R9
    sticky_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctl_q.err |=> ctl_q.err);
endmodule

// File: tb/lenfield_dma_splitter_bench.sv
`timescale 1ns/1ps
module lenfield_dma_splitter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] dsc_addr = '0, nxt_addr = '0;
    logic [7:0]  dsc_pos = '0, nxt_pos = '0;
    logic        dsc_nv = 1'b0, nxt_nv = 1'b0;
    logic        in_valid = 1'b0, in_last = 1'b0;
    logic [7:0]  in_data = '0;

    logic        wr_valid, lo_seen, hi_seen, retire, dma_en, drop_err;
    logic [15:0] wr_addr, buf_len, retire_len;
    logic [7:0]  wr_data;
    logic [1:0]  retire_code;

    always #10 clk = ~clk;

    lenfield_dma_splitter u_lenfield_dma_splitter (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start),
        .dsc_addr_i(dsc_addr), .dsc_pos_i(dsc_pos), .dsc_nv_i(dsc_nv),
        .nxt_addr_i(nxt_addr), .nxt_pos_i(nxt_pos), .nxt_nv_i(nxt_nv),
        .in_valid_i(in_valid), .in_data_i(in_data), .in_last_i(in_last),
        .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .lo_seen_o(lo_seen), .hi_seen_o(hi_seen), .buf_len_o(buf_len),
        .retire_o(retire), .retire_code_o(retire_code), .retire_len_o(retire_len),
        .dma_en_o(dma_en), .drop_err_o(drop_err)
    );

    int tests = 0;
    int fails = 0;

    // behavioural model state
    int m_en, m_base, m_pos, m_nv, m_cnt, m_lo, m_hi, m_len, m_err;
    int e_wv, e_wa, e_wd, e_ret, e_rc, e_rl;

    int addr_log[$];
    int rlen_log[$];
    int rcode_log[$];

    task automatic check(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_en = 0; m_base = 0; m_pos = 0; m_nv = 0; m_cnt = 0;
        m_lo = 0; m_hi = 0; m_len = 0; m_err = 0;
        e_wv = 0; e_wa = 0; e_wd = 0; e_ret = 0; e_rc = 0; e_rl = 0;
    endtask

    task automatic model_step();
        e_wv = 0; e_ret = 0;
        if (!rst_n) begin
            model_reset();
        end else if (m_en == 0) begin
            if (in_valid) m_err = 1;
            if (start) begin
                m_en = 1; m_base = dsc_addr; m_pos = dsc_pos; m_nv = dsc_nv;
                m_cnt = 0; m_lo = 0; m_hi = 0; m_len = 0;
            end
        end else if (in_valid) begin
            e_wv = 1;
            e_wa = (m_base + m_cnt) % 65536;
            e_wd = in_data;
            if (!m_lo && m_cnt == m_pos) begin
                m_lo = 1; m_len = (m_len / 256) * 256 + in_data;
            end
            if (!m_hi && m_cnt == m_pos + 1) begin
                m_hi = 1; m_len = (m_len % 256) + in_data * 256;
            end
            m_cnt++;
            if (m_hi && m_cnt >= m_len) begin
                e_ret = 1; e_rl = m_len;
                if (m_nv) begin
                    e_rc = 1; m_base = nxt_addr; m_pos = nxt_pos; m_nv = nxt_nv;
                    m_cnt = 0; m_lo = 0; m_hi = 0; m_len = 0;
                end else begin
                    m_en = 0; e_rc = in_last ? 1 : 2;
                end
            end
        end
    endtask

    task automatic compare();
        check("R2", "wr_valid", wr_valid, e_wv);
        check("R2", "wr_addr", wr_addr, e_wa);
        check("R2", "wr_data", wr_data, e_wd);
        check("R3", "lo_seen", lo_seen, m_lo);
        check("R3", "hi_seen", hi_seen, m_hi);
        check("R3", "buf_len", buf_len, m_len);
        check("R5", "retire", retire, e_ret);
        check("R5", "retire_code", retire_code, e_rc);
        check("R5", "retire_len", retire_len, e_rl);
        check("R7", "dma_en", dma_en, m_en);
        check("R9", "drop_err", drop_err, m_err);
        if (wr_valid) addr_log.push_back(wr_addr);
        if (retire) begin
            rlen_log.push_back(retire_len);
            rcode_log.push_back(retire_code);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        start = 1'b0; in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic begin_desc(int addr, int pos, int nv, int naddr, int npos, int nnv);
        dsc_addr = addr[15:0]; dsc_pos = pos[7:0]; dsc_nv = nv[0];
        nxt_addr = naddr[15:0]; nxt_pos = npos[7:0]; nxt_nv = nnv[0];
        start = 1'b1;
        step();
    endtask

    task automatic send(ref byte unsigned s[$], input int pkt, input bit gaps);
        for (int i = 0; i < s.size(); i++) begin
            in_valid = 1'b1;
            in_data  = s[i];
            in_last  = ((i + 1) % pkt == 0) || (i == s.size() - 1);
            step();
            if (gaps && (i % 7 == 6)) step();
        end
    endtask

    task automatic fill_msg(ref byte unsigned s[$], input int n, input int pos, input int len, input int seed);
        for (int i = 0; i < n; i++) begin
            if (i == pos)          s.push_back(len[7:0]);
            else if (i == pos + 1) s.push_back(len[15:8]);
            else                   s.push_back(8'((i * 13 + seed) & 255));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        byte unsigned s[$];
        model_reset();
        @(negedge clk);
        step(); step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        check("R1", "reset dma_en", dma_en, 0);
        check("R1", "reset flags", {lo_seen, hi_seen, drop_err, retire, wr_valid}, 0);
        check("R1", "reset code", retire_code, 0);
        check("R1", "reset buf_len", buf_len, 0);

        // Two concatenated messages 160 + 100 in 64-byte packets, chained descriptors
        begin_desc(16'h1000, 2, 1, 16'h2000, 2, 0);
        s.delete();
        fill_msg(s, 160, 2, 160, 5);
        fill_msg(s, 100, 2, 100, 9);
        addr_log.delete(); rlen_log.delete(); rcode_log.delete();
        send(s, 64, 1'b1);
        check("R6", "writes for two messages", addr_log.size(), 260);
        check("R2", "last addr of first msg", addr_log[159], 16'h1000 + 159);
        check("R6", "first addr after chain", addr_log[160], 16'h2000);
        check("R6", "last addr of second msg", addr_log[259], 16'h2000 + 99);
        check("R5", "retire count", rlen_log.size(), 2);
        check("R5", "first retire length", rlen_log[0], 160);
        check("R6", "second retire length", rlen_log[1], 100);
        check("R5", "first retire code", rcode_log[0], 1);
        check("R8", "end-of-packet retire code", rcode_log[1], 1);
        check("R8", "enable after final retire", dma_en, 0);
        step();

        // Length field split across a packet boundary
        begin_desc(16'h3000, 63, 0, 0, 0, 0);
        s.delete();
        fill_msg(s, 80, 63, 80, 3);
        for (int i = 0; i < 64; i++) begin
            in_valid = 1'b1; in_data = s[i]; in_last = (i == 63);
            step();
        end
        check("R4", "low byte captured before split", lo_seen, 1);
        check("R4", "high byte pending at split", hi_seen, 0);
        rlen_log.delete();
        for (int i = 64; i < 80; i++) begin
            in_valid = 1'b1; in_data = s[i]; in_last = (i == 79);
            step();
            if (i == 64) check("R4", "length after split", buf_len, 80);
        end
        check("R4", "split-length retire", rlen_log.size() == 1 ? rlen_log[0] : -1, 80);
        step();

        // Zero length and short length with chaining (6 + 3 bytes, one packet)
        begin_desc(16'h4000, 4, 1, 16'h5000, 0, 0);
        s.delete();
        fill_msg(s, 6, 4, 0, 1);
        fill_msg(s, 3, 0, 3, 2);
        addr_log.delete(); rlen_log.delete(); rcode_log.delete();
        send(s, 64, 1'b0);
        check("R10", "zero length retire", rlen_log.size() == 2 ? rlen_log[0] : -1, 0);
        check("R10", "short msg addr after zero length", addr_log[6], 16'h5000);
        check("R10", "second retire length", rlen_log.size() == 2 ? rlen_log[1] : -1, 3);
        step();

        // Overrun mid-packet, then dropped bytes
        check("R9", "no error before drops", drop_err, 0);
        begin_desc(16'h6000, 0, 0, 0, 0, 0);
        s.delete();
        fill_msg(s, 16, 0, 10, 7);
        addr_log.delete(); rlen_log.delete(); rcode_log.delete();
        send(s, 16, 1'b0);
        check("R7", "overrun code", rcode_log.size() == 1 ? rcode_log[0] : -1, 2);
        check("R7", "enable after overrun", dma_en, 0);
        check("R9", "dropped bytes not written", addr_log.size(), 10);
        check("R9", "drop error set", drop_err, 1);
        repeat (5) step();
        check("R9", "drop error sticky", drop_err, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule